// File: doc/BRIEF.md
# Flexible Immediate Constant Classifier

This block looks at a 32-bit candidate constant and decides whether a data-processing instruction can carry it as its flexible second operand. A constant qualifies when it is an 8-bit byte moved left by some number of bit positions without losing any set bit. It also qualifies when it follows one of three byte-replication patterns: one byte in the two even lanes with zeros between, one byte in the two odd lanes with zeros between, or one byte in all four lanes.

The classifier reports which form matched. For the shifted-byte form it also gives the byte and the smallest left shift. For the replicated forms it gives the repeated byte. A second result tells the instruction stage whether a flag-setting logical operation that uses the constant must write the carry flag, and with which value.

The block is purely combinational, so all results follow the input within the same clock cycle. Form codes are 0 for the shifted byte, 1 for even-lane replication, 2 for odd-lane replication and 3 for all-lane replication.

Top module: `imm_classifier`

## Requirements
- R1: An input from 0 to 255 gives valid=1, form=0, byte equal to the input, shift=0 and carry_touch=0.
- R2: An input above 255 that equals a byte shifted left by 1 to 24 gives valid=1, form=0, the smallest such shift and the matching byte. Whenever the shift is nonzero, bit 7 of the byte is therefore 1.
- R3: An input with lane 0 (bits 7:0) equal to lane 2 (bits 23:16), that byte nonzero, and lanes 1 and 3 zero gives valid=1, form=1, byte equal to the lane 0 value and shift=0.
- R4: An input with lane 1 (bits 15:8) equal to lane 3 (bits 31:24), that byte nonzero, and lanes 0 and 2 zero gives valid=1, form=2, byte equal to the lane 1 value and shift=0.
- R5: An input whose four bytes are equal, and which R1 does not cover, gives valid=1, form=3, byte equal to the repeated value and shift=0.
- R6: An input that matches no form gives valid=0 and drives form, byte, shift, carry_touch and carry_bit to 0. Values whose set bits wrap around from bit 31 to bit 0 are not legal.
- R7: A shifted-byte match above 255 gives carry_touch=1 and carry_bit equal to bit 31 of the input.
- R8: Replicated-form matches and inputs from 0 to 255 give carry_touch=0 and carry_bit=0, whatever bit 31 holds.
- R9: When one input value matches several forms, the shifted-byte form (including plain bytes) is reported ahead of any replicated form.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cand_word | input | 32 | Candidate constant |
| imm_valid | output | 1 | Constant is expressible |
| imm_form | output | 2 | Matched form code (0 shifted, 1 even lanes, 2 odd lanes, 3 all lanes) |
| imm_byte | output | 8 | Byte value of the matched form |
| imm_shift | output | 5 | Left shift for form 0, else 0 |
| carry_touch | output | 1 | Flag-setting logical op must write carry |
| carry_bit | output | 1 | Carry value to write when carry_touch is 1 |

## Verification
Every result is combinational, so it is due zero cycles after the input changes. The bench changes `cand_word` on the falling clock edge and samples all outputs 5 ns later, in the same low phase and before the next rising edge. It walks a vector table of boundary values: 255 and 256, shift 24, a top-bit byte, wrap-around values, and each replication pattern with bit 31 set and clear. It then sweeps one odd byte across every shift, which fixes both the smallest-shift choice and the point where the carry output switches on. Finally it sweeps a nine-bit pattern that can never fit in the byte window.

// File: rtl/imm_cls_pkg.sv
package imm_cls_pkg;
  typedef enum logic [1:0] {
    FORM_SHIFTED  = 2'd0,
    FORM_REP_EVEN = 2'd1,
    FORM_REP_ODD  = 2'd2,
    FORM_REP_ALL  = 2'd3
  } imm_form_e;
endpackage

// File: rtl/imm_shift_detect.sv
// Finds the smallest left shift that places every set bit of the word
// inside an 8-bit window.
module imm_shift_detect #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 5
) (
  input  logic [WORD_W-1:0]  word,
  output logic               hit,
  output logic [BYTE_W-1:0]  byte_val,
  output logic [SHIFT_W-1:0] shift_amt
);
  localparam int MAX_SHIFT = WORD_W - BYTE_W;
  localparam int NCAND     = MAX_SHIFT + 1;

  logic [NCAND-1:0] cand_hit;

  generate
    for (genvar s = 0; s < NCAND; s++) begin : g_cand
      localparam logic [WORD_W-1:0] WINDOW =
        {{(WORD_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}} << s;
      assign cand_hit[s] = ~|(word & ~WINDOW);
    end
  endgenerate

  function automatic logic [SHIFT_W-1:0] lowest_set(input logic [NCAND-1:0] v);
    logic [SHIFT_W-1:0] r;
    r = '0;
    for (int i = NCAND - 1; i >= 0; i--) begin
      if (v[i]) r = SHIFT_W'(i);
    end
    return r;
  endfunction

  always_comb begin
    hit       = |cand_hit;
    shift_amt = lowest_set(cand_hit);
    byte_val  = hit ? BYTE_W'(word >> shift_amt) : '0;
  end
endmodule

// File: rtl/imm_repl_detect.sv
// Compares byte lanes against lanes 0 and 1 for the replicated patterns.
module imm_repl_detect #(
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic [WORD_W-1:0] word,
  output logic              even_hit,
  output logic              odd_hit,
  output logic              all_hit,
  output logic [BYTE_W-1:0] lo_byte,
  output logic [BYTE_W-1:0] hi_byte
);
  localparam int LANES = WORD_W / BYTE_W;

  logic [BYTE_W-1:0] lane [LANES];
  logic [LANES-1:0]  even_ok;
  logic [LANES-1:0]  odd_ok;
  logic [LANES-1:0]  same_ok;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      assign lane[k]    = word[k*BYTE_W +: BYTE_W];
      assign same_ok[k] = (lane[k] == lane[0]);
      if (k % 2 == 0) begin : g_even
        assign even_ok[k] = (lane[k] == lane[0]);
        assign odd_ok[k]  = ~|lane[k];
      end else begin : g_odd
        assign even_ok[k] = ~|lane[k];
        assign odd_ok[k]  = (lane[k] == lane[1]);
      end
    end
  endgenerate

  always_comb begin
    lo_byte  = lane[0];
    hi_byte  = lane[1];
    even_hit = (&even_ok) && (|lane[0]);
    odd_hit  = (&odd_ok) && (|lane[1]);
    all_hit  = &same_ok;
  end
endmodule

// File: rtl/imm_form_select.sv
// Priority selection between detectors and carry side effect derivation.
module imm_form_select
  import imm_cls_pkg::*;
#(
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 5
) (
  input  logic               shift_hit,
  input  logic [BYTE_W-1:0]  shift_byte,
  input  logic [SHIFT_W-1:0] shift_amt,
  input  logic               even_hit,
  input  logic               odd_hit,
  input  logic               all_hit,
  input  logic [BYTE_W-1:0]  lo_byte,
  input  logic [BYTE_W-1:0]  hi_byte,
  input  logic               word_msb,
  input  logic               above_byte,
  output logic               valid,
  output imm_form_e          form,
  output logic [BYTE_W-1:0]  byte_out,
  output logic [SHIFT_W-1:0] shift_out,
  output logic               carry_touch,
  output logic               carry_bit
);
  function automatic logic needs_carry(input logic shifted, input logic big);
    return shifted && big;
  endfunction

  always_comb begin
    valid     = 1'b1;
    form      = FORM_SHIFTED;
    byte_out  = '0;
    shift_out = '0;
    if (shift_hit) begin
      byte_out  = shift_byte;
      shift_out = shift_amt;
    end else if (even_hit) begin
      form     = FORM_REP_EVEN;
      byte_out = lo_byte;
    end else if (odd_hit) begin
      form     = FORM_REP_ODD;
      byte_out = hi_byte;
    end else if (all_hit) begin
      form     = FORM_REP_ALL;
      byte_out = lo_byte;
    end else begin
      valid = 1'b0;
    end
    carry_touch = needs_carry(shift_hit, above_byte);
    carry_bit   = carry_touch && word_msb;
  end
endmodule

// File: rtl/imm_classifier.sv
module imm_classifier
  import imm_cls_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = $clog2(WORD_W - BYTE_W + 1)
) (
  input  logic [WORD_W-1:0]  cand_word,
  output logic               imm_valid,
  output logic [1:0]         imm_form,
  output logic [BYTE_W-1:0]  imm_byte,
  output logic [SHIFT_W-1:0] imm_shift,
  output logic               carry_touch,
  output logic               carry_bit
);
  logic               shift_hit;
  logic [BYTE_W-1:0]  shift_byte;
  logic [SHIFT_W-1:0] shift_amt;
  logic               rep_even_hit;
  logic               rep_odd_hit;
  logic               rep_all_hit;
  logic [BYTE_W-1:0]  rep_lo_byte;
  logic [BYTE_W-1:0]  rep_hi_byte;
  logic               above_byte;
  imm_form_e          form_sel;

  assign above_byte = |cand_word[WORD_W-1:BYTE_W];

  imm_shift_detect #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_shift (
    .word      (cand_word),
    .hit       (shift_hit),
    .byte_val  (shift_byte),
    .shift_amt (shift_amt)
  );

  imm_repl_detect #(.WORD_W(WORD_W), .BYTE_W(BYTE_W)) u_repl (
    .word     (cand_word),
    .even_hit (rep_even_hit),
    .odd_hit  (rep_odd_hit),
    .all_hit  (rep_all_hit),
    .lo_byte  (rep_lo_byte),
    .hi_byte  (rep_hi_byte)
  );

  imm_form_select #(.BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)) u_sel (
    .shift_hit   (shift_hit),
    .shift_byte  (shift_byte),
    .shift_amt   (shift_amt),
    .even_hit    (rep_even_hit),
    .odd_hit     (rep_odd_hit),
    .all_hit     (rep_all_hit),
    .lo_byte     (rep_lo_byte),
    .hi_byte     (rep_hi_byte),
    .word_msb    (cand_word[WORD_W-1]),
    .above_byte  (above_byte),
    .valid       (imm_valid),
    .form        (form_sel),
    .byte_out    (imm_byte),
    .shift_out   (imm_shift),
    .carry_touch (carry_touch),
    .carry_bit   (carry_bit)
  );

  assign imm_form = form_sel;
endmodule

// File: rtl/imm_classifier_chk.sv
module imm_classifier_chk #(
  parameter int WORD_W  = 32,
  parameter int BYTE_W  = 8,
  parameter int SHIFT_W = 5
) (
  input logic [WORD_W-1:0]  cand_word,
  input logic               imm_valid,
  input logic [1:0]         imm_form,
  input logic [BYTE_W-1:0]  imm_byte,
  input logic [SHIFT_W-1:0] imm_shift,
  input logic               carry_touch,
  input logic               carry_bit,
  input logic               shift_hit,
  input logic               rep_all_hit
);
  localparam int LANES = WORD_W / BYTE_W;

  always_comb begin
    if (~|cand_word[WORD_W-1:BYTE_W])
      assert_plain_byte_R1: assert (imm_valid && imm_form == 2'd0 &&
        imm_byte == cand_word[BYTE_W-1:0] && imm_shift == '0 && !carry_touch)
        else $error("plain byte misreported");
    if (imm_valid && imm_form == 2'd0)
      assert_shift_rebuild_R2: assert ((WORD_W'(imm_byte) << imm_shift) == cand_word)
        else $error("shifted byte does not rebuild input");
    if (imm_valid && imm_form == 2'd0 && imm_shift != '0)
      assert_smallest_shift_R2: assert (imm_byte[BYTE_W-1])
        else $error("shift not minimal");
    if (imm_valid && imm_form == 2'd1)
      assert_even_lanes_R3: assert (cand_word == {(LANES/2){{BYTE_W{1'b0}}, imm_byte}})
        else $error("even lane form mismatch");
    if (imm_valid && imm_form == 2'd2)
      assert_odd_lanes_R4: assert (cand_word == {(LANES/2){imm_byte, {BYTE_W{1'b0}}}})
        else $error("odd lane form mismatch");
    if (imm_valid && imm_form == 2'd3)
      assert_all_lanes_R5: assert (cand_word == {LANES{imm_byte}})
        else $error("all lane form mismatch");
    if (!imm_valid)
      assert_quiet_invalid_R6: assert (imm_form == 2'd0 && imm_byte == '0 &&
        imm_shift == '0 && !carry_touch && !carry_bit)
        else $error("invalid result not quiet");
    if (carry_touch)
      assert_carry_value_R7: assert (carry_bit == cand_word[WORD_W-1] && imm_valid &&
        imm_form == 2'd0 && |cand_word[WORD_W-1:BYTE_W])
        else $error("carry side effect wrong");
    if (imm_valid && imm_form != 2'd0)
      assert_no_carry_repl_R8: assert (!carry_touch && !carry_bit)
        else $error("replicated form touched carry");
    if (shift_hit && rep_all_hit)
      assert_priority_R9: assert (imm_form == 2'd0)
        else $error("priority violated");
  end
endmodule

bind imm_classifier imm_classifier_chk #(
  .WORD_W(WORD_W), .BYTE_W(BYTE_W), .SHIFT_W(SHIFT_W)
) u_chk (
  .cand_word   (cand_word),
  .imm_valid   (imm_valid),
  .imm_form    (imm_form),
  .imm_byte    (imm_byte),
  .imm_shift   (imm_shift),
  .carry_touch (carry_touch),
  .carry_bit   (carry_bit),
  .shift_hit   (shift_hit),
  .rep_all_hit (rep_all_hit)
);

// File: tb/imm_classifier_test.sv
module imm_classifier_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cand_word = '0;
  logic        imm_valid;
  logic [1:0]  imm_form;
  logic [7:0]  imm_byte;
  logic [4:0]  imm_shift;
  logic        carry_touch;
  logic        carry_bit;

  int tests_run = 0;
  int tests_failed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  imm_classifier uut (
    .cand_word   (cand_word),
    .imm_valid   (imm_valid),
    .imm_form    (imm_form),
    .imm_byte    (imm_byte),
    .imm_shift   (imm_shift),
    .carry_touch (carry_touch),
    .carry_bit   (carry_bit)
  );

  // {input, valid, form, byte, shift, carry_touch, carry_bit}
  localparam int NV = 17;
  localparam logic [49:0] VECS [NV] = '{
    {32'h0000_0000, 1'b1, 2'd0, 8'h00, 5'd0,  1'b0, 1'b0},  // R1 zero
    {32'h0000_00FF, 1'b1, 2'd0, 8'hFF, 5'd0,  1'b0, 1'b0},  // R1 top plain byte
    {32'h0000_0100, 1'b1, 2'd0, 8'h80, 5'd1,  1'b1, 1'b0},  // R2 R7 just above 255
    {32'h0000_3FC0, 1'b1, 2'd0, 8'hFF, 5'd6,  1'b1, 1'b0},  // R2
    {32'hFF00_0000, 1'b1, 2'd0, 8'hFF, 5'd24, 1'b1, 1'b1},  // R2 R7 max shift
    {32'h8000_0000, 1'b1, 2'd0, 8'h80, 5'd24, 1'b1, 1'b1},  // R7 top bit only
    {32'h01FE_0000, 1'b1, 2'd0, 8'hFF, 5'd17, 1'b1, 1'b0},  // R2
    {32'h00AB_00AB, 1'b1, 2'd1, 8'hAB, 5'd0,  1'b0, 1'b0},  // R3
    {32'h0001_0001, 1'b1, 2'd1, 8'h01, 5'd0,  1'b0, 1'b0},  // R3
    {32'hCD00_CD00, 1'b1, 2'd2, 8'hCD, 5'd0,  1'b0, 1'b0},  // R4 R8 bit31 set
    {32'h0100_0100, 1'b1, 2'd2, 8'h01, 5'd0,  1'b0, 1'b0},  // R4
    {32'h5A5A_5A5A, 1'b1, 2'd3, 8'h5A, 5'd0,  1'b0, 1'b0},  // R5
    {32'hFFFF_FFFF, 1'b1, 2'd3, 8'hFF, 5'd0,  1'b0, 1'b0},  // R5 R8
    {32'h0000_0101, 1'b0, 2'd0, 8'h00, 5'd0,  1'b0, 1'b0},  // R6 nine bits wide
    {32'h00AB_00AC, 1'b0, 2'd0, 8'h00, 5'd0,  1'b0, 1'b0},  // R6 near miss
    {32'h1234_5678, 1'b0, 2'd0, 8'h00, 5'd0,  1'b0, 1'b0},  // R6
    {32'hF000_000F, 1'b0, 2'd0, 8'h00, 5'd0,  1'b0, 1'b0}   // R6 wrap-around
  };

  task automatic check(input string tag, input logic [17:0] exp);
    logic [17:0] act;
    act = {imm_valid, imm_form, imm_byte, imm_shift, carry_touch, carry_bit};
    tests_run++;
    if (act !== exp) begin
      tests_failed++;
      $display("FAIL %s: in=%h actual=%h expected=%h", tag, cand_word, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    cand_word = w;
    #5;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // R1: state after reset with zero input
    apply(32'h0);
    check("R1 reset", {1'b1, 2'd0, 8'h00, 5'd0, 1'b0, 1'b0});

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i][49:18]);
      check($sformatf("vector %0d", i), VECS[i][17:0]);
    end

    // R2 R7 R9: odd byte across every shift; smallest shift equals s
    for (int s = 0; s <= 24; s++) begin
      apply(32'h81 << s);
      check($sformatf("R2/R7 sweep s=%0d", s),
            {1'b1, 2'd0, 8'h81, 5'(s), (s > 0), (s == 24)});
    end

    // R6: nine-bit pattern never fits the byte window
    for (int s = 0; s <= 23; s++) begin
      apply(32'h181 << s);
      check($sformatf("R6 sweep s=%0d", s), 18'h0);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
    $finish;
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      tests_run++;
      tests_failed++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
      $finish;
    end
  end
endmodule